// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a bank of already-synchronized input pins and raises an interrupt when a pin meets the condition chosen for it. Each pin has its own control word. A 4-bit mode field in that word selects one of these behaviours: no detection, level low, level high, rising edge, falling edge, or either edge. A pin that meets its condition sets its bit in a shared flag word. Software clears a flag by writing a one to that bit. A single request line is raised whenever any flag is set.

Software reaches the block through a simple write-strobe register bus. The read data is combinational and follows the address. The control words sit at a stride of four bytes, so the word for pin n is at address n*4. The flag word is at its own fixed address. Edge modes compare the current pin sample with the sample from the previous clock. Level modes set the flag again on every cycle that the level holds, so a flag cleared while the condition is still true comes straight back.

Top module: `pin_irq_unit`

## Requirements
- R1: The control word of pin n is at byte address n*4 (n from 0 to NUM_PINS-1). Only bits 19:16 are stored, as the mode field. A read returns the mode field in bits 19:16 and zero in every other bit. A write takes effect on the next clock.
- R2: Mode 0x8 (level low) sets the pin's flag on every clock where the pin is 0. Mode 0xC (level high) sets the flag on every clock where the pin is 1.
- R3: Mode 0x9 sets the flag when the pin is 1 and was 0 on the previous clock. Mode 0xA sets the flag when the pin is 0 and was 1 on the previous clock. Mode 0xB sets the flag on either change. The previous-clock sample is 0 out of reset.
- R4: Mode 0x0, and every code other than 0x8, 0x9, 0xA, 0xB and 0xC, never sets a flag.
- R5: The flag word is at address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. Writing all ones clears every flag that has no new detection.
- R6: A level-mode flag that is cleared while its level still holds is set again on the clock of the clear.
- R7: When a clear and a new detection hit the same pin on the same clock, the flag ends up set.
- R8: irq_req equals the OR of all flags, delayed by one clock.
- R9: After reset, all mode fields, all flags and irq_req are zero. Addresses that are not registers read as zero.
- R10: Writing 0 to a pin's control word stops all further detection on that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_level | input | NUM_PINS | Synchronized pin levels |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_flags | output | NUM_PINS | Status flags |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 pins, an 8-bit address and a 32-bit data word. With these values every control address and the flag address at 0xA0 are in reach, along with the top pin, 31. Eight pins are set to the six defined modes and two undefined codes, and pin 31 is driven as well. A step-by-step model computes the flags, the request and the read data on every clock. The bench then aims clear writes at pins whose level holds or whose edge arrives on the same clock.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_BOTH = 4'hB,
    MODE_HIGH = 4'hC
  } irq_mode_e;

  function automatic logic mode_hit(input logic [MODE_W-1:0] code,
                                    input logic cur, input logic prev);
    logic r;
    case (code)
      MODE_LOW:  r = !cur;
      MODE_HIGH: r = cur;
      MODE_RISE: r = cur && !prev;
      MODE_FALL: r = !cur && prev;
      MODE_BOTH: r = cur ^ prev;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pinirq_cfg_bank.sv
module pinirq_cfg_bank
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [MODE_W-1:0]          wr_field,
  output logic [NUM_PINS*MODE_W-1:0] cfg_flat
);

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(n * 4);
    logic              sel;
    logic [MODE_W-1:0] cfg_d, cfg_q;

    always_comb begin
      sel   = wr_en && (addr == MY_ADDR);
      cfg_d = cfg_q;
      if (sel) cfg_d = wr_field;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
    end

    assign cfg_flat[n*MODE_W +: MODE_W] = cfg_q;

    assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == MY_ADDR) |=> (cfg_q == $past(wr_field)));
  end

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pins,
  input  logic [NUM_PINS*MODE_W-1:0] cfg_flat,
  output logic [NUM_PINS-1:0]        hit
);

  logic [NUM_PINS-1:0] prev_d, prev_q;

  always_comb prev_d = pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_det
    logic [MODE_W-1:0] code;
    assign code   = cfg_flat[n*MODE_W +: MODE_W];
    assign hit[n] = mode_hit(code, pins[n], prev_q[n]);

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == MODE_OFF) |-> !hit[n]);
    assert_rise_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (code == MODE_RISE && pins[n] && !$past(pins[n])) |-> hit[n]);
  end

endmodule

// File: rtl/pinirq_flags.sv
module pinirq_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] hit,
  output logic [NUM_PINS-1:0] flags
);

  logic [NUM_PINS-1:0] flags_d, flags_q;

  always_comb flags_d = (flags_q & ~clr_mask) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(clr_mask & ~hit)) == '0));
  assert_hit_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~flags_q) == '0));

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int FIELD_LSB   = 16,
  parameter int STATUS_ADDR = 'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] irq_flags,
  output logic                irq_req
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [NUM_PINS*MODE_W-1:0] cfg_flat;
  logic [NUM_PINS-1:0]        hit;
  logic [NUM_PINS-1:0]        clr_mask;
  logic                       stat_wr;

  pinirq_cfg_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .wr_en(bus_wr_en), .addr(bus_addr),
    .wr_field(bus_wdata[FIELD_LSB +: MODE_W]), .cfg_flat(cfg_flat));

  pinirq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n_i), .pins(pin_level), .cfg_flat(cfg_flat), .hit(hit));

  always_comb begin
    stat_wr  = bus_wr_en && (bus_addr == STAT_A);
    clr_mask = stat_wr ? bus_wdata[NUM_PINS-1:0] : '0;
  end

  pinirq_flags #(.NUM_PINS(NUM_PINS)) u_flg (
    .clk(clk), .rst_n(rst_n_i), .clr_mask(clr_mask), .hit(hit), .flags(irq_flags));

  logic irq_d, irq_q;
  always_comb irq_d = |irq_flags;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end
  assign irq_req = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_A) bus_rdata = DATA_W'(irq_flags);
    for (int n = 0; n < NUM_PINS; n++) begin
      if (bus_addr == ADDR_W'(n * 4))
        bus_rdata = DATA_W'(cfg_flat[n*MODE_W +: MODE_W]) << FIELD_LSB;
    end
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (|irq_flags) |=> irq_req);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(|irq_flags) |=> !irq_req);

endmodule

// File: tb/pin_irq_unit_test.sv
module pin_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_level = '0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_flags;
  logic        irq_req;

  always #5 clk = ~clk;

  pin_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_flags(irq_flags), .irq_req(irq_req));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_cfg [32];
  logic [31:0] m_flags = '0;
  logic [31:0] m_prev = '0;
  logic        m_irq = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'hA0) return m_flags;
    if (a < 8'd128 && a[1:0] == 2'b00) return 32'(m_cfg[a >> 2]) << 16;
    return '0;
  endfunction

  function automatic bit pin_fires(input int code, input bit cur, input bit prv);
    if (code == 8)  return !cur;
    if (code == 12) return cur;
    if (code == 9)  return cur && !prv;
    if (code == 10) return !cur && prv;
    if (code == 11) return cur != prv;
    return 0;
  endfunction

  task automatic model_advance(input bit wr, input logic [7:0] a,
                               input logic [31:0] d, input logic [31:0] p);
    logic [31:0] nf;
    nf = m_flags;
    if (wr && a == 8'hA0) nf = nf & ~d;
    for (int i = 0; i < 32; i++)
      if (pin_fires(m_cfg[i], p[i], m_prev[i])) nf[i] = 1'b1;
    m_irq   = (m_flags != 0);
    m_flags = nf;
    if (wr && a < 8'd128 && a[1:0] == 2'b00) m_cfg[a >> 2] = int'(d[19:16]);
    m_prev = p;
  endtask

  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] p, input string tag);
    @(negedge clk);
    bus_wr_en = wr; bus_addr = a; bus_wdata = d; pin_level = p;
    #1;
    check(tag, "rdata", bus_rdata, model_read(a));
    model_advance(wr, a, d, p);
    @(posedge clk);
    #1;
    check(tag, "flags", irq_flags, m_flags);
    check(tag, "irq_req", {31'b0, irq_req}, {31'b0, m_irq});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pins;
    logic [31:0] lfsr;
    for (int i = 0; i < 32; i++) m_cfg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9: reset state, idle cycles and unmapped addresses
    step(0, 8'h00, 0, 0, "R9");
    step(0, 8'h04, 0, 0, "R9");
    step(0, 8'h02, 0, 0, "R9");
    step(0, 8'hFC, 0, 0, "R9");
    step(0, 8'hA0, 0, 0, "R9");
    // R1: field stored, other bits dropped, read back next cycle
    step(1, 8'h0C, 32'hFFF9FFFF, 0, "R1");
    step(0, 8'h0C, 0, 0, "R1");
    step(1, 8'h7C, 32'h000B0000, 0, "R1");
    step(0, 8'h7C, 0, 0, "R1");
    // configure: p0 low, p1 high, p2 fall, p3 rise, p4 both, p5 off, p6 0x5, p7 0xF
    step(1, 8'h00, 32'h00080000, 0, "R2");
    step(1, 8'h04, 32'h000C0000, 0, "R2");
    step(1, 8'h08, 32'h000A0000, 0, "R3");
    step(1, 8'h10, 32'h000B0000, 0, "R3");
    step(1, 8'h14, 32'h00000000, 0, "R4");
    step(1, 8'h18, 32'h00050000, 0, "R4");
    step(1, 8'h1C, 32'h000F0000, 0, "R4");
    step(1, 8'hA0, 32'hFFFFFFFF, 0, "R5");
    // R2 R3 R4: varied pin patterns with periodic clears
    lfsr = 32'h1D2C3B4A;
    for (int k = 0; k < 60; k++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      pins = {lfsr[30], 23'b0, lfsr[23:16]};
      if (k % 5 == 4) step(1, 8'hA0, 32'hFFFFFFFF, pins, "R3");
      else            step(0, 8'hA0, 0, pins, "R2");
    end
    // R5: writing zero changes nothing, partial clear, full clear
    step(0, 8'hA0, 0, 32'h0000_0003, "R5");
    step(1, 8'hA0, 32'h0, 32'h0000_0003, "R5");
    step(1, 8'hA0, 32'h0000_0010, 32'h0000_0003, "R5");
    step(1, 8'hA0, 32'hFFFFFFFF, 32'h0000_0003, "R5");
    // R6: pin1 high (level high) keeps re-setting after clears
    step(1, 8'hA0, 32'h0000_0002, 32'h0000_0003, "R6");
    step(0, 8'hA0, 0, 32'h0000_0003, "R6");
    // R7: rising edge on pin3 with simultaneous clear of bit 3
    step(0, 8'hA0, 0, 32'h0000_0001, "R7");
    step(1, 8'hA0, 32'h0000_0008, 32'h0000_0009, "R7");
    step(0, 8'hA0, 0, 32'h0000_0009, "R7");
    step(1, 8'hA0, 32'hFFFFFFFF, 32'h0000_0001, "R8");
    step(0, 8'hA0, 0, 32'h0000_0001, "R8");
    step(0, 8'hA0, 0, 32'h0000_0001, "R8");
    // R10: disable pin4 (either edge) and toggle it
    step(1, 8'h10, 32'h0, 32'h0000_0001, "R10");
    step(1, 8'hA0, 32'hFFFFFFFF, 32'h0000_0011, "R10");
    step(0, 8'hA0, 0, 32'h0000_0001, "R10");
    step(0, 8'h10, 0, 32'h0000_0011, "R10");
    // R3: top pin 31 either edge
    step(0, 8'hA0, 0, 32'h8000_0001, "R3");
    step(0, 8'hA0, 0, 32'h0000_0001, "R3");
    step(1, 8'hA0, 32'hFFFFFFFF, 32'h0000_0001, "R8");
    step(0, 8'hA0, 0, 32'h0000_0001, "R8");
    step(0, 8'hA0, 0, 32'h0000_0001, "R8");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule